// File: doc/BRIEF.md
# Banked GPIO Controller with Set/Clear Writes

This block drives and observes up to 128 general-purpose pins, grouped in banks of 32. Each bank has its own small group of word registers on a 32-bit register bus. Software raises pins by writing ones to the bank's level register and lowers them by writing ones to its clear register. A pin touched by either write becomes an output in the same cycle, so no separate direction write is needed. A third write-one register hands pins back to input mode. Reading the level register returns the bank's pin levels after a two-flop synchronizer.

When reset is released, the block records the synchronized levels of pins 0 to 63 in two read-only words. These give software the state the board presented at power-up. Each pin also has a dedicated interrupt output that pulses for one cycle when the pin, while an input, changes level.

The bus has no handshake. A write takes effect on the clock edge where `bus_wr_en` is high, and read data follows `bus_addr` combinationally in the same cycle. Both have a fixed latency, so there is no back-pressure.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it, `pin_oe`, `pin_out` and `pin_irq` are all zero.
- R2: Bank b occupies byte addresses b*0x10 to b*0x10+0xC, and bit k of its registers is pin 32*b+k. A write of data D to offset 0x0 of bank b sets `pin_out` high, from the next clock edge, for every pin whose bit in D is 1.
- R3: A write of D to offset 0x4 of bank b drives `pin_out` low, from the next clock edge, for every pin whose bit in D is 1.
- R4: A pin written with a 1 through offset 0x0 or 0x4 also gets its `pin_oe` bit set by the same edge. Pins whose bit is 0 keep both `pin_out` and `pin_oe` unchanged, and so does every pin when no write occurs.
- R5: A write of D to offset 0x8 of bank b clears `pin_oe` for every pin whose bit in D is 1, and leaves `pin_out` unchanged.
- R6: A read of offset 0x0 of bank b returns `pin_in` bits 32*b+31 to 32*b, delayed by two clock edges. Reads of offsets 0x4 and 0x8 return zero.
- R7: Byte address 0x100 returns the synchronized levels of pins 0–31 and 0x104 those of pins 32–63, as sampled on the first clock edge after reset is released. These words do not change afterwards, and writes to them are ignored.
- R8: `pin_irq[n]` is high for exactly one cycle, two clock edges after `pin_in[n]` changes, if pin n is an input. It stays low for pins whose `pin_oe` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (9) | Byte address, word aligned |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS (128) | Raw pin levels |
| pin_out | output | NUM_PINS (128) | Output level per pin |
| pin_oe | output | NUM_PINS (128) | Output enable per pin |
| pin_irq | output | NUM_PINS (128) | Per-pin level-change pulse |

## Verification
Walking single-bit set and clear writes across all 128 pins expose a bank decode or bit-mapping fault. Such a fault would move a level onto the wrong pin or the wrong bank. Writes of zero and mixed patterns catch a design that treats the set and clear registers as plain stores, which would drag unrelated pins low or switch them to outputs. The direction-clear writes show whether the output latch is disturbed. The reset-capture words are read before and after the pins change, and again after a write to them, to catch a capture that keeps tracking the pins. Each pin is toggled in turn to check the interrupt's exact cycle, its one-cycle width and its index, and a toggle on an output pin must raise no interrupt.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int BANK_W = 32;
  localparam logic [1:0] OFS_LEVEL  = 2'd0;
  localparam logic [1:0] OFS_CLR    = 2'd1;
  localparam logic [1:0] OFS_DIRCLR = 2'd2;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET,
    OP_CLR,
    OP_DIRCLR
  } bank_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  // Free-running through reset so the capture sees real levels at release.
  always_ff @(posedge clk) begin
    stage1 <= d;
    q      <= stage1;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  bank_op_e          op,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lvl,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] oe_q,
  output logic [BANK_W-1:0] irq
);
  logic [BANK_W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      unique case (op)
        OP_SET: begin
          out_q <= out_q | wdata;
          oe_q  <= oe_q | wdata;
        end
        OP_CLR: begin
          out_q <= out_q & ~wdata;
          oe_q  <= oe_q | wdata;
        end
        OP_DIRCLR: oe_q <= oe_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) lvl_prev <= lvl;

  assign irq = {BANK_W{armed}} & (lvl ^ lvl_prev) & ~oe_q;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SET |=> ((out_q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLR |=> ((out_q & $past(wdata)) == '0)); // R3
  AST_WRITE_ENABLES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET || op == OP_CLR) |=> ((oe_q & $past(wdata)) == $past(wdata))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_NONE |=> ($stable(out_q) && $stable(oe_q))); // R4
  AST_DIRCLR_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DIRCLR |=> (((oe_q & $past(wdata)) == '0) && $stable(out_q))); // R5
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_irq
);
  localparam int NUM_BANKS = NUM_PINS / BANK_W;
  localparam int CAP_WORDS = (NUM_BANKS < 2) ? NUM_BANKS : 2;
  localparam int CAP_BITS  = CAP_WORDS * BANK_W;

  initial begin
    if (NUM_PINS % BANK_W != 0 || NUM_PINS < BANK_W || NUM_PINS > 128)
      $error("NUM_PINS must be a multiple of 32 between 32 and 128");
  end

  logic [NUM_PINS-1:0] lvl_sync;
  logic                armed;
  logic [CAP_BITS-1:0] cap_q;

  logic                    aligned, in_bank_space, in_cap_space;
  logic [ADDR_W-6:0]       bank_field;
  logic [1:0]              reg_ofs;

  assign aligned       = (bus_addr[1:0] == 2'b00);
  assign in_bank_space = aligned && !bus_addr[ADDR_W-1];
  assign in_cap_space  = aligned && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:3] == '0);
  assign bank_field    = bus_addr[ADDR_W-2:4];
  assign reg_ofs       = bus_addr[3:2];

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk (clk),
    .d   (pin_in),
    .q   (lvl_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cap_q <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
      cap_q <= lvl_sync[CAP_BITS-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_op_e op;

    always_comb begin
      op = OP_NONE;
      if (bus_wr_en && in_bank_space && (int'(bank_field) == b)) begin
        unique case (reg_ofs)
          OFS_LEVEL:  op = OP_SET;
          OFS_CLR:    op = OP_CLR;
          OFS_DIRCLR: op = OP_DIRCLR;
          default:    op = OP_NONE;
        endcase
      end
    end

    gpio_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .armed (armed),
      .op    (op),
      .wdata (bus_wdata),
      .lvl   (lvl_sync[b*BANK_W +: BANK_W]),
      .out_q (pin_out[b*BANK_W +: BANK_W]),
      .oe_q  (pin_oe[b*BANK_W +: BANK_W]),
      .irq   (pin_irq[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (in_bank_space && reg_ofs == OFS_LEVEL) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (int'(bank_field) == b) bus_rdata = lvl_sync[b*BANK_W +: BANK_W];
    end else if (in_cap_space) begin
      for (int w = 0; w < CAP_WORDS; w++)
        if (int'(bus_addr[2]) == w) bus_rdata = cap_q[w*BANK_W +: BANK_W];
    end
  end

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(cap_q)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (pin_oe == '0 && pin_out == '0 && pin_irq == '0)); // R1
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [NP-1:0] exp_out = '0;
  logic [NP-1:0] exp_oe = '0;

  always #10 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    cyc(1);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, NP'(bus_rdata), NP'(exp));
  endtask

  task automatic model(input int b, input int ofs, input logic [31:0] d);
    for (int k = 0; k < 32; k++) begin
      if (d[k]) begin
        if (ofs == 0) begin exp_out[b*32+k] = 1'b1; exp_oe[b*32+k] = 1'b1; end
        if (ofs == 1) begin exp_out[b*32+k] = 1'b0; exp_oe[b*32+k] = 1'b1; end
        if (ofs == 2) exp_oe[b*32+k] = 1'b0;
      end
    end
  endtask

  task automatic chk_pins(input string req);
    chk(pin_out == exp_out, {req, " out"}, pin_out, exp_out);
    chk(pin_oe == exp_oe, {req, " oe"}, pin_oe, exp_oe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] p0;
    p0 = {32'h1357_9BDF, 32'h0246_8ACE, 32'h3C3C_A5A5, 32'hA5C3_0F96};
    @(negedge clk);
    pin_in = p0;
    cyc(6);
    // R1: quiet during reset
    chk(pin_oe == '0, "R1 oe in reset", pin_oe, '0);
    chk(pin_out == '0, "R1 out in reset", pin_out, '0);
    chk(pin_irq == '0, "R1 irq in reset", pin_irq, '0);
    rst_n = 1'b1;
    cyc(1);
    chk(pin_oe == '0 && pin_out == '0, "R1 after release", pin_oe | pin_out, '0);
    chk(pin_irq == '0, "R1 irq after release", pin_irq, '0);
    // R7: reset capture words
    rd_chk(9'h100, p0[31:0], "R7 capture low");
    rd_chk(9'h104, p0[63:32], "R7 capture high");
    pin_in = ~p0;
    cyc(4);
    wr(9'h100, 32'hFFFF_0000);
    wr(9'h104, 32'h0000_FFFF);
    rd_chk(9'h100, p0[31:0], "R7 capture held low");
    rd_chk(9'h104, p0[63:32], "R7 capture held high");
    chk_pins("R7 capture writes ignored");

    // R2 R4: walking set over all pins
    for (int p = 0; p < NP; p++) begin
      wr(9'((p / 32) * 16), 32'(1) << (p % 32));
      model(p / 32, 0, 32'(1) << (p % 32));
      chk(pin_out == exp_out, "R2 walking set", pin_out, exp_out);
      chk(pin_oe == exp_oe, "R4 set enables", pin_oe, exp_oe);
    end
    // R3: walking clear on even pins
    for (int p = 0; p < NP; p += 2) begin
      wr(9'((p / 32) * 16 + 4), 32'(1) << (p % 32));
      model(p / 32, 1, 32'(1) << (p % 32));
      chk(pin_out == exp_out, "R3 walking clear", pin_out, exp_out);
      chk(pin_oe == exp_oe, "R4 clear keeps oe", pin_oe, exp_oe);
    end
    // R2 R3 R5: mixed patterns over all banks and offsets
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] d;
        int o;
        d = 32'h9E37_79B9 * 32'(k + 1) + 32'(b * 7);
        o = (k + b) % 3;
        wr(9'(b * 16 + o * 4), d);
        model(b, o, d);
        chk_pins(o == 0 ? "R2 pattern set" : (o == 1 ? "R3 pattern clear" : "R5 pattern dirclr"));
      end
    end
    // R4: zero writes change nothing
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 3; o++) begin
        wr(9'(b * 16 + o * 4), 32'h0);
        chk_pins("R4 zero write");
      end
    // R5: return every pin to input, outputs kept
    for (int b = 0; b < 4; b++) begin
      wr(9'(b * 16 + 8), 32'hFFFF_FFFF);
      model(b, 2, 32'hFFFF_FFFF);
      chk_pins("R5 dirclr all");
    end

    // R6: level reads
    for (int k = 0; k < 6; k++) begin
      logic [NP-1:0] pat;
      pat = {32'(k) * 32'h0123_4567 + 32'd1, 32'(k) * 32'h89AB_CDEF,
             ~(32'(k) * 32'h1111_1111), 32'(k) << 3};
      pin_in = pat;
      cyc(1);
      cyc(1);
      for (int b = 0; b < 4; b++) begin
        rd_chk(9'(b * 16), pat[b*32 +: 32], "R6 level read");
        rd_chk(9'(b * 16 + 4), 32'h0, "R6 clear reads zero");
        rd_chk(9'(b * 16 + 8), 32'h0, "R6 dirclr reads zero");
      end
    end

    // R8: per-pin interrupt pulse, all pins inputs
    cyc(4);
    chk(pin_irq == '0, "R8 quiet before sweep", pin_irq, '0);
    for (int p = 0; p < NP; p++) begin
      pin_in[p] = ~pin_in[p];
      cyc(1);
      chk(pin_irq == '0, "R8 not yet", pin_irq, '0);
      cyc(1);
      chk(pin_irq == (NP'(1) << p), "R8 pulse index", pin_irq, NP'(1) << p);
      cyc(1);
      chk(pin_irq == '0, "R8 one cycle", pin_irq, '0);
    end
    // R8: output pin raises nothing
    wr(9'h000, 32'h0000_0020);
    wr(9'h034, 32'h0001_0000);
    pin_in[5] = ~pin_in[5];
    pin_in[112] = ~pin_in[112];
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk(pin_irq == '0, "R8 output pins silent", pin_irq, '0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule